// File: doc/BRIEF.md
# Packed complex multiply datapath

This block is a three-stage pipelined multiplier for complex numbers stored in interleaved form. Each step takes two 128-bit words of operand A and two of operand B. Each word carries two complex values as four signed 32-bit elements: real, imaginary, real, imaginary. One step therefore multiplies four complex pairs.

The first stage gathers the real and imaginary parts of both operands into separate lane vectors, using byte-index shuffles over each word pair. The second stage forms the partial products −bd and bc for every lane. The third stage finishes each lane with a multiply-add: ac + (−bd) gives the real part and ad + bc gives the imaginary part. The same stage interleaves the results again into two output words, using merge-high and merge-low shuffles.

An upstream vector engine streams one operand group per cycle into the block. The block never stalls, so input ready is always high.

Top module: `cmul_pipe`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during reset.
- R2: A step is accepted when `in_valid` is 1 at a rising edge. Its result shows on `out_valid`/`out_w0`/`out_w1` after the third rising edge, counting the accepting edge as the first. `out_valid` is 1 only for cycles that carry such a result.
- R3: While `rst` is 1 at a rising edge, all pipeline valid bits clear. Steps already in flight are dropped and `out_valid` stays 0 until a new step has passed through.
- R4: Byte 0 of a word is its most significant byte, and element e (0..3) of a word occupies bits [127-32e : 96-32e]. Word 0 holds re0, im0, re1, im1 and word 1 holds re2, im2, re3, im3, for both the A and the B operands.
- R5: For complex index k, the real result is the low 32 bits of a_re·b_re − a_im·b_im, computed in signed two's complement and wrapping on overflow.
- R6: For complex index k, the imaginary result is the low 32 bits of a_re·b_im + a_im·b_re, computed in signed two's complement and wrapping on overflow.
- R7: The output uses the same layout as the input (R4). `out_w0` carries results 0 and 1 and `out_w1` carries results 2 and 3, so multiplying by 1+0i returns operand A unchanged.
- R8: Steps accepted on consecutive cycles produce results on consecutive cycles, in order, with no bubble.
- R9: A step whose A operand words, or whose B operand words, are all zero produces all-zero output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand group present this cycle |
| in_ready | output | 1 | Always 1, no back-pressure |
| a_w0 | input | 128 | Operand A, complex values 0 and 1 |
| a_w1 | input | 128 | Operand A, complex values 2 and 3 |
| b_w0 | input | 128 | Operand B, complex values 0 and 1 |
| b_w1 | input | 128 | Operand B, complex values 2 and 3 |
| out_valid | output | 1 | Result words valid |
| out_w0 | output | 128 | Products 0 and 1, interleaved |
| out_w1 | output | 128 | Products 2 and 3, interleaved |

## Verification
The assertions check the valid chain on every cycle. Each valid bit must move one stage per edge, an output may appear only three edges after an accepted step, and reset must clear every stage. They also check that a zero operand always yields zero words. The arithmetic itself, meaning the wrap of each lane, the element order of the gather and merge shuffles, and the correspondence between input and output indices, is shown only by the bench. Its reference model and its directed scenarios cover identity, extreme values, back-to-back bursts and a reset taken with steps in flight.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int LANE_W     = 32;
  localparam int LANES      = 4;
  localparam int WORD_W     = LANES * LANE_W;
  localparam int BYTE_N     = WORD_W / 8;
  localparam int LANE_BYTES = LANE_W / 8;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {PAT_REAL, PAT_IMAG, PAT_MRG_HI, PAT_MRG_LO} pat_e;

  // Source byte index (into the 2*BYTE_N concatenation) for output byte j.
  function automatic int pat_index(pat_e p, int j);
    int e;
    int b;
    e = j / LANE_BYTES;
    b = j % LANE_BYTES;
    case (p)
      PAT_REAL:   return 2 * e * LANE_BYTES + b;
      PAT_IMAG:   return 2 * e * LANE_BYTES + LANE_BYTES + b;
      PAT_MRG_HI: return (e % 2) * BYTE_N + (e / 2) * LANE_BYTES + b;
      default:    return (e % 2) * BYTE_N + (e / 2) * LANE_BYTES + BYTE_N / 2 + b;
    endcase
  endfunction

  // Byte shuffle over {x, y}; byte 0 is the most significant byte of x.
  function automatic word_t byte_shuffle(word_t x, word_t y, pat_e p);
    logic [2*WORD_W-1:0] cat;
    word_t r;
    int idx;
    cat = {x, y};
    r = '0;
    for (int j = 0; j < BYTE_N; j++) begin
      idx = pat_index(p, j);
      r[WORD_W-1-8*j -: 8] = cat[2*WORD_W-1-8*idx -: 8];
    end
    return r;
  endfunction

  function automatic lane_t lane_of(word_t w, int k);
    return w[WORD_W-1-LANE_W*k -: LANE_W];
  endfunction

  function automatic logic [2*LANE_W-1:0] wide_mul(lane_t m0, lane_t m1);
    logic signed [2*LANE_W-1:0] s0;
    logic signed [2*LANE_W-1:0] s1;
    s0 = $signed({{LANE_W{m0[LANE_W-1]}}, m0});
    s1 = $signed({{LANE_W{m1[LANE_W-1]}}, m1});
    return s0 * s1;
  endfunction

  // acc + m0*m1, low LANE_W bits
  function automatic lane_t mul_add(lane_t m0, lane_t m1, lane_t acc);
    logic [2*LANE_W-1:0] prod;
    prod = wide_mul(m0, m1);
    return prod[LANE_W-1:0] + acc;
  endfunction

  // sub - m0*m1, low LANE_W bits
  function automatic lane_t neg_mul_sub(lane_t m0, lane_t m1, lane_t sub);
    logic [2*LANE_W-1:0] prod;
    prod = wide_mul(m0, m1);
    return sub - prod[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/cmul_gather.sv
module cmul_gather
  import cmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid_in,
  input  word_t a_w0,
  input  word_t a_w1,
  input  word_t b_w0,
  input  word_t b_w1,
  output logic  valid_q,
  output word_t a_re_q,
  output word_t a_im_q,
  output word_t b_re_q,
  output word_t b_im_q
);
  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
  end

  always_ff @(posedge clk) begin
    if (valid_in) begin
      a_re_q <= byte_shuffle(a_w0, a_w1, PAT_REAL);
      a_im_q <= byte_shuffle(a_w0, a_w1, PAT_IMAG);
      b_re_q <= byte_shuffle(b_w0, b_w1, PAT_REAL);
      b_im_q <= byte_shuffle(b_w0, b_w1, PAT_IMAG);
    end
  end
endmodule

// File: rtl/cmul_partial.sv
module cmul_partial
  import cmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid_in,
  input  word_t a_re,
  input  word_t a_im,
  input  word_t b_re,
  input  word_t b_im,
  output logic  valid_q,
  output word_t a_re_q,
  output word_t b_re_q,
  output word_t b_im_q,
  output word_t nbd_q,
  output word_t bc_q
);
  wire word_t nbd_d;
  wire word_t bc_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign nbd_d[WORD_W-1-LANE_W*k -: LANE_W] =
      neg_mul_sub(lane_of(a_im, k), lane_of(b_im, k), '0);
    assign bc_d[WORD_W-1-LANE_W*k -: LANE_W] =
      mul_add(lane_of(a_im, k), lane_of(b_re, k), '0);
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
  end

  always_ff @(posedge clk) begin
    if (valid_in) begin
      nbd_q  <= nbd_d;
      bc_q   <= bc_d;
      a_re_q <= a_re;
      b_re_q <= b_re;
      b_im_q <= b_im;
    end
  end
endmodule

// File: rtl/cmul_finish.sv
module cmul_finish
  import cmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid_in,
  input  word_t a_re,
  input  word_t b_re,
  input  word_t b_im,
  input  word_t nbd,
  input  word_t bc,
  output logic  valid_q,
  output word_t out_w0_q,
  output word_t out_w1_q
);
  wire word_t re_d;
  wire word_t im_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign re_d[WORD_W-1-LANE_W*k -: LANE_W] =
      mul_add(lane_of(a_re, k), lane_of(b_re, k), lane_of(nbd, k));
    assign im_d[WORD_W-1-LANE_W*k -: LANE_W] =
      mul_add(lane_of(a_re, k), lane_of(b_im, k), lane_of(bc, k));
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_in;
  end

  always_ff @(posedge clk) begin
    if (valid_in) begin
      out_w0_q <= byte_shuffle(re_d, im_d, PAT_MRG_HI);
      out_w1_q <= byte_shuffle(re_d, im_d, PAT_MRG_LO);
    end
  end
endmodule

// File: rtl/cmul_pipe.sv
module cmul_pipe
  import cmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  word_t a_w0,
  input  word_t a_w1,
  input  word_t b_w0,
  input  word_t b_w1,
  output logic  out_valid,
  output word_t out_w0,
  output word_t out_w1
);
  logic  s1_valid;
  logic  s2_valid;
  word_t s1_a_re, s1_a_im, s1_b_re, s1_b_im;
  word_t s2_a_re, s2_b_re, s2_b_im, s2_nbd, s2_bc;

  assign in_ready = 1'b1;

  cmul_gather i_gather (
    .clk(clk), .rst(rst), .valid_in(in_valid),
    .a_w0(a_w0), .a_w1(a_w1), .b_w0(b_w0), .b_w1(b_w1),
    .valid_q(s1_valid),
    .a_re_q(s1_a_re), .a_im_q(s1_a_im), .b_re_q(s1_b_re), .b_im_q(s1_b_im)
  );

  cmul_partial i_partial (
    .clk(clk), .rst(rst), .valid_in(s1_valid),
    .a_re(s1_a_re), .a_im(s1_a_im), .b_re(s1_b_re), .b_im(s1_b_im),
    .valid_q(s2_valid),
    .a_re_q(s2_a_re), .b_re_q(s2_b_re), .b_im_q(s2_b_im),
    .nbd_q(s2_nbd), .bc_q(s2_bc)
  );

  cmul_finish i_finish (
    .clk(clk), .rst(rst), .valid_in(s2_valid),
    .a_re(s2_a_re), .b_re(s2_b_re), .b_im(s2_b_im),
    .nbd(s2_nbd), .bc(s2_bc),
    .valid_q(out_valid), .out_w0_q(out_w0), .out_w1_q(out_w1)
  );
endmodule

// File: rtl/cmul_pipe_chk.sv
module cmul_pipe_chk
  import cmul_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  in_valid,
  input logic  s1_valid,
  input logic  s2_valid,
  input logic  out_valid,
  input word_t a_w0,
  input word_t a_w1,
  input word_t b_w0,
  input word_t b_w1,
  input word_t out_w0,
  input word_t out_w1
);
  AST_ACCEPT_S1: assert property (@(posedge clk) disable iff (rst) in_valid |=> s1_valid); // R2
  AST_IDLE_S1: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !s1_valid); // R2
  AST_ADVANCE_S2: assert property (@(posedge clk) disable iff (rst) s1_valid |=> s2_valid); // R8
  AST_ADVANCE_OUT: assert property (@(posedge clk) disable iff (rst) s2_valid |=> out_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !s2_valid |=> !out_valid); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid, 3)); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!s1_valid && !s2_valid && !out_valid)); // R3
  AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(a_w0, 3) == '0 && $past(a_w1, 3) == '0) |-> (out_w0 == '0 && out_w1 == '0)); // R9
  AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(b_w0, 3) == '0 && $past(b_w1, 3) == '0) |-> (out_w0 == '0 && out_w1 == '0)); // R9
endmodule

bind cmul_pipe cmul_pipe_chk i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .s1_valid(s1_valid), .s2_valid(s2_valid), .out_valid(out_valid),
  .a_w0(a_w0), .a_w1(a_w1), .b_w0(b_w0), .b_w1(b_w1),
  .out_w0(out_w0), .out_w1(out_w1)
);

// File: tb/test_cmul_pipe.sv
module test_cmul_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [127:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic in_ready, out_valid;
  logic [127:0] o0, o1;

  always #5 clk = ~clk;

  cmul_pipe i_cmul_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_w0(a0), .a_w1(a1), .b_w0(b0), .b_w1(b1),
    .out_valid(out_valid), .out_w0(o0), .out_w1(o1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  typedef struct {
    bit v;
    logic [127:0] w0;
    logic [127:0] w1;
  } exp_t;
  exp_t q[$];

  function automatic logic [31:0] el(logic [127:0] w, int e);
    logic [127:0] t;
    t = w >> ((3 - e) * 32);
    return t[31:0];
  endfunction

  function automatic exp_t model(logic [127:0] x0, logic [127:0] x1,
                                 logic [127:0] y0, logic [127:0] y1);
    exp_t r;
    logic [31:0] oe [8];
    for (int k = 0; k < 4; k++) begin
      logic [127:0] wa, wb;
      longint ar, ai, br, bi, re, im;
      wa = (k < 2) ? x0 : x1;
      wb = (k < 2) ? y0 : y1;
      ar = longint'($signed(el(wa, 2 * (k % 2))));
      ai = longint'($signed(el(wa, 2 * (k % 2) + 1)));
      br = longint'($signed(el(wb, 2 * (k % 2))));
      bi = longint'($signed(el(wb, 2 * (k % 2) + 1)));
      re = ar * br - ai * bi;
      im = ar * bi + ai * br;
      oe[2*k]   = re[31:0];
      oe[2*k+1] = im[31:0];
    end
    r.v  = 1'b0;
    r.w0 = {oe[0], oe[1], oe[2], oe[3]};
    r.w1 = {oe[4], oe[5], oe[6], oe[7]};
    return r;
  endfunction

  // reference pipeline history, one entry per rising edge
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      q.delete();
      e.v = 1'b0; e.w0 = '0; e.w1 = '0;
      for (int i = 0; i < 3; i++) q.push_back(e);
    end else begin
      e = model(a0, a1, b0, b1);
      e.v = in_valid;
      q.push_back(e);
      if (q.size() > 8) void'(q.pop_front());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done && q.size() >= 3) begin
      exp_t e;
      e = q[q.size() - 3];
      checks++;
      if (out_valid !== e.v) begin
        errors++;
        $display("FAIL R2 R8 out_valid actual %b expected %b", out_valid, e.v);
      end else if (e.v) begin
        for (int i = 0; i < 8; i++) begin
          logic [31:0] act, exv;
          act = (i < 4) ? el(o0, i) : el(o1, i - 4);
          exv = (i < 4) ? el(e.w0, i) : el(e.w1, i - 4);
          checks++;
          if (act !== exv) begin
            errors++;
            if (i % 2 == 0)
              $display("FAIL R5 R4 R7 real element %0d actual %h expected %h", i, act, exv);
            else
              $display("FAIL R6 R4 R7 imag element %0d actual %h expected %h", i, act, exv);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exv);
    end
  endtask

  task automatic put(logic [127:0] x0, logic [127:0] x1,
                     logic [127:0] y0, logic [127:0] y1);
    @(negedge clk);
    a0 = x0; a1 = x1; b0 = y0; b1 = y1;
    in_valid = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [127:0] ta0, ta1, one;
    one = {32'd1, 32'd0, 32'd1, 32'd0};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R3 out_valid in reset", {127'd0, out_valid}, 128'd0);
    chk(in_ready === 1'b1, "R1 in_ready in reset", {127'd0, in_ready}, 128'd1);
    rst = 1'b0;
    idle(2);
    chk(out_valid === 1'b0, "R3 out_valid after reset", {127'd0, out_valid}, 128'd0);

    // identity: multiply by 1+0i returns A in the same order
    ta0 = {32'd11, 32'd12, 32'd21, 32'd22};
    ta1 = {32'd31, 32'hFFFF_FFF0, 32'h8000_0000, 32'h7FFF_FFFF};
    put(ta0, ta1, one, one);
    idle(3);
    chk(out_valid === 1'b1 && o0 === ta0, "R7 R4 identity word0", o0, ta0);
    chk(o1 === ta1, "R7 R4 identity word1", o1, ta1);
    idle(2);

    // small known values: (1+2i)(3+4i) = -5+10i in complex 0
    put({32'd1, 32'd2, 32'd0, 32'd0}, '0, {32'd3, 32'd4, 32'd0, 32'd0}, '0);
    idle(3);
    chk(o0 === {32'hFFFF_FFFB, 32'd10, 32'd0, 32'd0}, "R5 R6 known product", o0,
        {32'hFFFF_FFFB, 32'd10, 32'd0, 32'd0});

    // zero A operand
    put('0, '0, rnd128(), rnd128());
    idle(3);
    chk(o0 === '0 && o1 === '0, "R9 zero operand", o0 | o1, '0);

    // extremes: wrap on overflow
    put({4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}}, {4{32'h8000_0001}});
    put({4{32'hFFFF_FFFF}}, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, {4{32'hFFFF_FFFF}});
    idle(4);

    // back-to-back burst
    for (int i = 0; i < 16; i++) put(rnd128(), rnd128(), rnd128(), rnd128());
    idle(2);
    // burst with gaps
    for (int i = 0; i < 10; i++) begin
      put(rnd128(), rnd128(), rnd128(), rnd128());
      if (i % 3 == 0) idle(1);
    end
    idle(4);

    // reset with steps in flight
    put(rnd128(), rnd128(), rnd128(), rnd128());
    put(rnd128(), rnd128(), rnd128(), rnd128());
    @(negedge clk);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(out_valid === 1'b0, "R3 flushed by reset", {127'd0, out_valid}, 128'd0);
      @(negedge clk);
    end
    chk(in_ready === 1'b1, "R1 in_ready after run", {127'd0, in_ready}, 128'd1);

    put(rnd128(), rnd128(), rnd128(), rnd128());
    idle(5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule